// File: doc/BRIEF.md
# Tile Network Interface and Configuration Controller

This block sits between an on-chip word network and one processing tile. Every operation arrives as a header word, then a length word. The header names one of four operations. The first writes address/data pairs into the tile's configuration store. The second is a block run: it fills the tile's local memory, starts the core, waits for the core to report completion, then sends the result words out. The third sends words from local memory without running the core. The fourth is a stream, in which words pass through to the core while the core's results go back to the network in the same cycles.

Both network directions use a valid/ready word handshake. The core is reached through three paths:
- a start/done pulse pair for block runs;
- a pair of word streams for stream operations;
- a read port into the configuration store and a read/write port into local memory.

Only the controller can write the configuration store. A configuration operation that names a few addresses leaves every other location unchanged, so a tile can be partly reconfigured without reloading everything.

Top module: `tile_netif_ctrl`

## Requirements
- R1: After reset, `busy` is 0, `in_ready` is 1, and `out_valid`, `core_start` and `core_sin_valid` are all 0.
- R2: The operation code is bits [15:14] of the header word: 00 configure, 01 block run, 10 unload, 11 stream. The other header bits are ignored. The next word is the length N. When N is 0, the operation ends as soon as the length word is taken and moves no data.
- R3: A configure operation takes N pairs of words, an address word then a data word. Each data word is written to the configuration location named by its address word. It reads back on `cfg_rd_data` from the following cycle. A pair whose address is CFG_DEPTH or higher is dropped, and reading such an address returns 0.
- R4: A configure operation changes only the addresses it names. All other configuration locations keep their contents.
- R5: A block run behaves as follows:
  - It writes its N input words to local memory addresses 0 to N-1.
  - In the cycle after the last input word is taken, `core_start` is high for exactly one cycle. In that cycle `in_ready` and `out_valid` are both 0.
  - After `core_done`, it sends the words at local memory addresses 0 to N-1 to the network, in address order.
- R6: `core_done` is ignored, and writes through the core's memory port are ignored, in every state except the wait that follows `core_start`.
- R7: An unload operation sends the words at local memory addresses 0 to N-1 in order, without raising `core_start`.
- R8: A stream operation behaves as follows:
  - It passes N network words to `core_sin` unchanged, with `in_ready` following `core_sin_ready`.
  - It passes N `core_sout` words to the network unchanged.
  - The two directions are counted independently and may each transfer in the same cycle.
- R9: `core_sin_valid` is 0 outside a stream operation. Once a stream operation has taken its N input words, `in_ready` and `core_sin_valid` both stay 0 until the operation ends.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` holds its value in the next cycle. No word is lost or repeated.
- R11: `busy` rises in the cycle after the header word is taken. It falls in the cycle after the operation's last word is transferred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Network input word valid |
| in_data | input | WORD_W | Network input word |
| in_ready | output | 1 | Controller accepts the input word |
| out_valid | output | 1 | Network output word valid |
| out_data | output | WORD_W | Network output word |
| out_ready | input | 1 | Network accepts the output word |
| busy | output | 1 | An operation is in progress |
| core_start | output | 1 | One-cycle start pulse to the core (block run) |
| core_done | input | 1 | Core completion pulse |
| core_sin_valid | output | 1 | Stream word to the core is valid |
| core_sin_data | output | WORD_W | Stream word to the core |
| core_sin_ready | input | 1 | Core accepts the stream word |
| core_sout_valid | input | 1 | Core result word is valid |
| core_sout_data | input | WORD_W | Core result word |
| core_sout_ready | output | 1 | Controller takes the core result word |
| cfg_rd_addr | input | CFG_AW | Core read address into the configuration store |
| cfg_rd_data | output | WORD_W | Configuration word at cfg_rd_addr |
| core_mem_we | input | 1 | Core write strobe into local memory |
| core_mem_addr | input | DATA_AW | Core local memory address |
| core_mem_wdata | input | WORD_W | Core local memory write word |
| core_mem_rdata | output | WORD_W | Local memory word at core_mem_addr |

## Verification
In a stream operation, one clock edge can carry both a network word into the core and a core result word out to the network. The bench provokes this by adding one to each word in a behavioural core and by driving `core_sin_ready` and `out_ready` from independent pseudo-random bits. It counts the edges on which both transfers happen, requires that count to be non-zero, and checks every output word in order against a queue of expected values. A second stream holds `out_ready` low while the inputs go in. It then offers extra input words and expects them to be refused while the backlog of results is still waiting.

// File: rtl/tnc_pkg.sv
`timescale 1ns/1ps
package tnc_pkg;

   typedef enum logic [1:0] {
      OP_CFG    = 2'b00,
      OP_BLOCK  = 2'b01,
      OP_UNLOAD = 2'b10,
      OP_STREAM = 2'b11
   } op_e;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_LEN,
      ST_CFG_A,
      ST_CFG_D,
      ST_BLK_LD,
      ST_BLK_GO,
      ST_BLK_WAIT,
      ST_UNLD,
      ST_STRM
   } state_e;

endpackage

// File: rtl/tnc_cfg_store.sv
`timescale 1ns/1ps
module tnc_cfg_store #(
   parameter int WORD_W = 16,
   parameter int DEPTH  = 1400,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [WORD_W-1:0] rd_data
);

   localparam logic [WORD_W-1:0] DEPTH_W = WORD_W'(DEPTH);

   logic [WORD_W-1:0] mem [DEPTH];
   logic              wr_hit;

   // Writes outside the store are dropped.
   assign wr_hit = (wr_addr < DEPTH_W);

   always_ff @(posedge clk) begin
      if (wr_en && wr_hit) begin
         mem[wr_addr[AW-1:0]] <= wr_data;
      end
   end

   generate
      if (DEPTH == (1 << AW)) begin : g_full_range
         // Every read address is inside the store.
         assign rd_data = mem[rd_addr];
      end else begin : g_guarded
         localparam logic [AW-1:0] DEPTH_A = AW'(DEPTH);
         assign rd_data = (rd_addr < DEPTH_A) ? mem[rd_addr] : '0;
      end
   endgenerate

endmodule

// File: rtl/tnc_local_mem.sv
`timescale 1ns/1ps
module tnc_local_mem #(
   parameter int WORD_W = 16,
   parameter int DEPTH  = 256,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [AW-1:0]     raddr_net,
   output logic [WORD_W-1:0] rdata_net,
   input  logic [AW-1:0]     raddr_core,
   output logic [WORD_W-1:0] rdata_core
);

   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         mem[waddr] <= wdata;
      end
   end

   // Both read ports see the array with no register in between.
   assign rdata_net  = mem[raddr_net];
   assign rdata_core = mem[raddr_core];

endmodule

// File: rtl/tnc_sequencer.sv
`timescale 1ns/1ps
module tnc_sequencer
   import tnc_pkg::*;
#(
   parameter int WORD_W  = 16,
   parameter int DATA_AW = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [WORD_W-1:0]  in_data,
   output logic               in_ready,
   output logic               out_valid,
   output logic [WORD_W-1:0]  out_data,
   input  logic               out_ready,
   output logic               busy,
   output logic               core_start,
   input  logic               core_done,
   output logic               core_sin_valid,
   input  logic               core_sin_ready,
   input  logic               core_sout_valid,
   input  logic [WORD_W-1:0]  core_sout_data,
   output logic               core_sout_ready,
   output logic               cfg_we,
   output logic [WORD_W-1:0]  cfg_waddr,
   output logic               ld_we,
   output logic [DATA_AW-1:0] ld_addr,
   output logic [DATA_AW-1:0] unld_addr,
   input  logic [WORD_W-1:0]  unld_data,
   output logic               core_wr_allow
);

   state_e            state_q, state_d;
   op_e               op_q, op_d;
   logic [WORD_W-1:0] len_q, len_d;
   logic [WORD_W-1:0] addr_q, addr_d;
   logic [WORD_W-1:0] cin_q, cin_d, cin_nx;
   logic [WORD_W-1:0] cout_q, cout_d, cout_nx;
   logic              in_fire, out_fire;
   logic              in_last, out_last;
   logic              in_done, out_done;
   logic              strm_end;

   assign cin_nx   = cin_q + WORD_W'(1);
   assign cout_nx  = cout_q + WORD_W'(1);
   assign in_last  = (cin_nx == len_q);
   assign out_last = (cout_nx == len_q);
   assign in_done  = (cin_q == len_q);
   assign out_done = (cout_q == len_q);
   assign in_fire  = in_valid & in_ready;
   assign out_fire = out_valid & out_ready;

   assign strm_end = (in_done  | (in_fire  & in_last)) &
                     (out_done | (out_fire & out_last));

   // Handshake outputs, decoded from the state.
   always_comb begin
      in_ready        = 1'b0;
      out_valid       = 1'b0;
      core_sin_valid  = 1'b0;
      core_sout_ready = 1'b0;
      unique case (state_q)
         ST_IDLE, ST_LEN, ST_CFG_A, ST_CFG_D, ST_BLK_LD: begin
            in_ready = 1'b1;
         end
         ST_UNLD: begin
            out_valid = 1'b1;
         end
         ST_STRM: begin
            in_ready        = core_sin_ready & ~in_done;
            core_sin_valid  = in_valid & ~in_done;
            out_valid       = core_sout_valid & ~out_done;
            core_sout_ready = out_ready & ~out_done;
         end
         default: begin
         end
      endcase
   end

   assign out_data      = (state_q == ST_STRM) ? core_sout_data : unld_data;
   assign unld_addr     = cout_q[DATA_AW-1:0];
   assign ld_addr       = cin_q[DATA_AW-1:0];
   assign ld_we         = (state_q == ST_BLK_LD) & in_fire;
   assign cfg_we        = (state_q == ST_CFG_D) & in_fire;
   assign cfg_waddr     = addr_q;
   assign core_start    = (state_q == ST_BLK_GO);
   assign core_wr_allow = (state_q == ST_BLK_WAIT);
   assign busy          = (state_q != ST_IDLE);

   always_comb begin
      state_d = state_q;
      op_d    = op_q;
      len_d   = len_q;
      addr_d  = addr_q;
      cin_d   = cin_q;
      cout_d  = cout_q;
      unique case (state_q)
         ST_IDLE: begin
            if (in_fire) begin
               op_d    = op_e'(in_data[WORD_W-1 -: 2]);
               state_d = ST_LEN;
            end
         end
         ST_LEN: begin
            if (in_fire) begin
               len_d  = in_data;
               cin_d  = '0;
               cout_d = '0;
               if (in_data == '0) begin
                  state_d = ST_IDLE;
               end else begin
                  unique case (op_q)
                     OP_CFG:    state_d = ST_CFG_A;
                     OP_BLOCK:  state_d = ST_BLK_LD;
                     OP_UNLOAD: state_d = ST_UNLD;
                     default:   state_d = ST_STRM;
                  endcase
               end
            end
         end
         ST_CFG_A: begin
            if (in_fire) begin
               addr_d  = in_data;
               state_d = ST_CFG_D;
            end
         end
         ST_CFG_D: begin
            if (in_fire) begin
               cin_d   = cin_nx;
               state_d = in_last ? ST_IDLE : ST_CFG_A;
            end
         end
         ST_BLK_LD: begin
            if (in_fire) begin
               cin_d = cin_nx;
               if (in_last) state_d = ST_BLK_GO;
            end
         end
         ST_BLK_GO: begin
            state_d = ST_BLK_WAIT;
         end
         ST_BLK_WAIT: begin
            if (core_done) state_d = ST_UNLD;
         end
         ST_UNLD: begin
            if (out_fire) begin
               cout_d = cout_nx;
               if (out_last) state_d = ST_IDLE;
            end
         end
         ST_STRM: begin
            if (in_fire)  cin_d  = cin_nx;
            if (out_fire) cout_d = cout_nx;
            if (strm_end) state_d = ST_IDLE;
         end
         default: begin
            state_d = ST_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         op_q    <= OP_CFG;
         len_q   <= '0;
         addr_q  <= '0;
         cin_q   <= '0;
         cout_q  <= '0;
      end else begin
         state_q <= state_d;
         op_q    <= op_d;
         len_q   <= len_d;
         addr_q  <= addr_d;
         cin_q   <= cin_d;
         cout_q  <= cout_d;
      end
   end

endmodule

// File: rtl/tile_netif_ctrl.sv
`timescale 1ns/1ps
module tile_netif_ctrl #(
   parameter int  WORD_W     = 16,
   parameter int  CFG_DEPTH  = 1400,
   parameter int  DATA_DEPTH = 256,
   localparam int CFG_AW     = $clog2(CFG_DEPTH),
   localparam int DATA_AW    = $clog2(DATA_DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [WORD_W-1:0]  in_data,
   output logic               in_ready,
   output logic               out_valid,
   output logic [WORD_W-1:0]  out_data,
   input  logic               out_ready,
   output logic               busy,
   output logic               core_start,
   input  logic               core_done,
   output logic               core_sin_valid,
   output logic [WORD_W-1:0]  core_sin_data,
   input  logic               core_sin_ready,
   input  logic               core_sout_valid,
   input  logic [WORD_W-1:0]  core_sout_data,
   output logic               core_sout_ready,
   input  logic [CFG_AW-1:0]  cfg_rd_addr,
   output logic [WORD_W-1:0]  cfg_rd_data,
   input  logic               core_mem_we,
   input  logic [DATA_AW-1:0] core_mem_addr,
   input  logic [WORD_W-1:0]  core_mem_wdata,
   output logic [WORD_W-1:0]  core_mem_rdata
);

   // Parameter checks at elaboration.
   if (WORD_W < 8) begin : g_chk_word
      $error("WORD_W must be at least 8");
   end
   if (CFG_DEPTH < 2 || CFG_DEPTH > (1 << WORD_W)) begin : g_chk_cfg
      $error("CFG_DEPTH must lie in 2 .. 2**WORD_W");
   end
   if (DATA_DEPTH < 2 || DATA_DEPTH != (1 << DATA_AW)) begin : g_chk_data
      $error("DATA_DEPTH must be a power of two, at least 2");
   end
   if (DATA_AW > WORD_W) begin : g_chk_aw
      $error("DATA_DEPTH exceeds the length range");
   end

   logic               cfg_we;
   logic [WORD_W-1:0]  cfg_waddr;
   logic               ld_we;
   logic [DATA_AW-1:0] ld_addr;
   logic [DATA_AW-1:0] unld_addr;
   logic [WORD_W-1:0]  unld_data;
   logic               core_wr_allow;
   logic               mem_we;
   logic [DATA_AW-1:0] mem_waddr;
   logic [WORD_W-1:0]  mem_wdata;

   tnc_sequencer #(
      .WORD_W  (WORD_W),
      .DATA_AW (DATA_AW)
   ) u_seq (
      .clk             (clk),
      .rst_n           (rst_n),
      .in_valid        (in_valid),
      .in_data         (in_data),
      .in_ready        (in_ready),
      .out_valid       (out_valid),
      .out_data        (out_data),
      .out_ready       (out_ready),
      .busy            (busy),
      .core_start      (core_start),
      .core_done       (core_done),
      .core_sin_valid  (core_sin_valid),
      .core_sin_ready  (core_sin_ready),
      .core_sout_valid (core_sout_valid),
      .core_sout_data  (core_sout_data),
      .core_sout_ready (core_sout_ready),
      .cfg_we          (cfg_we),
      .cfg_waddr       (cfg_waddr),
      .ld_we           (ld_we),
      .ld_addr         (ld_addr),
      .unld_addr       (unld_addr),
      .unld_data       (unld_data),
      .core_wr_allow   (core_wr_allow)
   );

   assign core_sin_data = in_data;

   tnc_cfg_store #(
      .WORD_W (WORD_W),
      .DEPTH  (CFG_DEPTH)
   ) u_cfg (
      .clk     (clk),
      .wr_en   (cfg_we),
      .wr_addr (cfg_waddr),
      .wr_data (in_data),
      .rd_addr (cfg_rd_addr),
      .rd_data (cfg_rd_data)
   );

   // Network loads take the write port first. The core may write only
   // while the controller waits for it to finish.
   assign mem_we    = ld_we | (core_mem_we & core_wr_allow);
   assign mem_waddr = ld_we ? ld_addr : core_mem_addr;
   assign mem_wdata = ld_we ? in_data : core_mem_wdata;

   tnc_local_mem #(
      .WORD_W (WORD_W),
      .DEPTH  (DATA_DEPTH)
   ) u_mem (
      .clk        (clk),
      .we         (mem_we),
      .waddr      (mem_waddr),
      .wdata      (mem_wdata),
      .raddr_net  (unld_addr),
      .rdata_net  (unld_data),
      .raddr_core (core_mem_addr),
      .rdata_core (core_mem_rdata)
   );

endmodule

// File: rtl/tnc_chk.sv
`timescale 1ns/1ps
module tnc_chk #(
   parameter int WORD_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_ready,
   input logic              out_valid,
   input logic              out_ready,
   input logic [WORD_W-1:0] out_data,
   input logic              busy,
   input logic              core_start,
   input logic              core_sin_valid,
   input logic              core_sin_ready
);

   a_r10_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)))
      else $error("R10 output word changed or dropped while stalled");

   a_r5_start_single: assert property (@(posedge clk) disable iff (!rst_n)
      core_start |=> !core_start)
      else $error("R5 start pulse longer than one cycle");

   a_r5_start_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      core_start |-> (busy && !in_ready && !out_valid))
      else $error("R5 network active during start");

   a_r9_no_feed_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !core_sin_valid)
      else $error("R9 core fed while idle");

   a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (in_ready && !out_valid && !core_start))
      else $error("R11 idle state not quiet");

   a_r8_sin_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
      (core_sin_valid && !core_sin_ready) |-> !in_ready)
      else $error("R8 input taken while core stalls");

   a_r6_start_not_streaming: assert property (@(posedge clk) disable iff (!rst_n)
      core_sin_valid |-> !core_start)
      else $error("R6 start during stream");

endmodule

bind tile_netif_ctrl tnc_chk #(.WORD_W(WORD_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .in_ready       (in_ready),
   .out_valid      (out_valid),
   .out_ready      (out_ready),
   .out_data       (out_data),
   .busy           (busy),
   .core_start     (core_start),
   .core_sin_valid (core_sin_valid),
   .core_sin_ready (core_sin_ready)
);

// File: tb/tb_tile_netif_ctrl.sv
`timescale 1ns/1ps
module tb_tile_netif_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [15:0] in_data = '0;
   logic        in_ready;
   logic        out_valid;
   logic [15:0] out_data;
   logic        out_ready = 1'b0;
   logic        busy;
   logic        core_start;
   logic        core_done = 1'b0;
   logic        core_sin_valid;
   logic [15:0] core_sin_data;
   logic        core_sin_ready = 1'b0;
   logic        core_sout_valid = 1'b0;
   logic [15:0] core_sout_data = '0;
   logic        core_sout_ready;
   logic [10:0] cfg_rd_addr = '0;
   logic [15:0] cfg_rd_data;
   logic        core_mem_we = 1'b0;
   logic [7:0]  core_mem_addr = '0;
   logic [15:0] core_mem_wdata = '0;
   logic [15:0] core_mem_rdata;

   int          total = 0;
   int          bad = 0;
   int          start_cnt = 0;
   int          both_cnt = 0;
   logic [15:0] exp_q[$];
   logic [15:0] core_q[$];
   bit          hold_out = 1'b0;
   bit          s_sin_fire = 1'b0;
   bit          s_sout_fire = 1'b0;
   logic [15:0] s_sin_data = '0;
   bit          prev_stall = 1'b0;
   logic [15:0] prev_data = '0;
   logic [15:0] lfsr = 16'hACE1;
   string       cur_req = "R5";

   always #2.5 clk = ~clk;

   tile_netif_ctrl dut (
      .clk (clk), .rst_n (rst_n),
      .in_valid (in_valid), .in_data (in_data), .in_ready (in_ready),
      .out_valid (out_valid), .out_data (out_data), .out_ready (out_ready),
      .busy (busy), .core_start (core_start), .core_done (core_done),
      .core_sin_valid (core_sin_valid), .core_sin_data (core_sin_data),
      .core_sin_ready (core_sin_ready),
      .core_sout_valid (core_sout_valid), .core_sout_data (core_sout_data),
      .core_sout_ready (core_sout_ready),
      .cfg_rd_addr (cfg_rd_addr), .cfg_rd_data (cfg_rd_data),
      .core_mem_we (core_mem_we), .core_mem_addr (core_mem_addr),
      .core_mem_wdata (core_mem_wdata), .core_mem_rdata (core_mem_rdata)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic report();
      $display("test done: total=%0d bad=%0d", total, bad);
   endtask

   // Offer one word. Returns at the falling edge after the word is taken.
   task automatic send_word(input logic [15:0] w);
      in_valid = 1'b1;
      in_data  = w;
      #1;
      while (!in_ready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic send_header(input logic [15:0] w);
      send_word(w);
      #1 check("R11 busy after header", 32'(busy), 32'd1);
      @(negedge clk);
   endtask

   task automatic drain_and_idle(input string req);
      while (exp_q.size() != 0) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      #1 check(req, 32'(busy), 32'd0);
      @(negedge clk);
   endtask

   task automatic cfg_expect(input logic [10:0] a, input logic [15:0] exp, input string req);
      cfg_rd_addr = a;
      #1 check(req, 32'(cfg_rd_data), 32'(exp));
      @(negedge clk);
   endtask

   // Network side ready, stream core model (result = input + 1), output monitor.
   always @(negedge clk) begin
      if (s_sin_fire)  core_q.push_back(s_sin_data + 16'd1);
      if (s_sout_fire) void'(core_q.pop_front());
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      out_ready      = hold_out ? 1'b0 : (lfsr[0] | lfsr[3]);
      core_sin_ready = lfsr[5] | lfsr[8];
      core_sout_valid = (core_q.size() != 0);
      core_sout_data  = (core_q.size() != 0) ? core_q[0] : 16'h0;
      #2;
      s_sin_fire  = rst_n && core_sin_valid && core_sin_ready;
      s_sin_data  = core_sin_data;
      s_sout_fire = rst_n && core_sout_valid && core_sout_ready;
      if (rst_n) begin
         if (prev_stall) begin
            check("R10 hold valid", 32'(out_valid), 32'd1);
            check("R10 hold data", 32'(out_data), 32'(prev_data));
         end
         prev_stall = out_valid && !out_ready;
         prev_data  = out_data;
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               check({cur_req, " unexpected word"}, 32'(out_data), 32'hFFFF_FFFF);
            end else begin
               check({cur_req, " word"}, 32'(out_data), 32'(exp_q.pop_front()));
            end
            if (s_sin_fire) both_cnt++;
         end
         if (core_start) start_cnt++;
      end
   end

   // Block core model: after start, rewrite addresses 0 and 1, then finish.
   always begin
      @(negedge clk);
      #2;
      if (rst_n && core_start) begin
         @(negedge clk);
         @(negedge clk);
         for (int i = 0; i < 2; i++) begin
            core_mem_we    = 1'b1;
            core_mem_addr  = 8'(i);
            core_mem_wdata = 16'hC000 | 16'(i);
            @(negedge clk);
         end
         core_mem_we = 1'b0;
         core_done   = 1'b1;
         @(negedge clk);
         core_done = 1'b0;
      end
   end

   task automatic run_block(input int n, input logic [15:0] base, input bit junk);
      cur_req = "R5";
      send_header(16'h7FFF);
      send_word(16'(n));
      if (junk) begin
         // R6: strobes offered before the start must have no effect.
         core_mem_we    = 1'b1;
         core_mem_addr  = 8'd6;
         core_mem_wdata = 16'hDEAD;
         core_done      = 1'b1;
      end
      for (int i = 0; i < n; i++) begin
         if (i < 2) exp_q.push_back(16'hC000 | 16'(i));
         else       exp_q.push_back(base + 16'(i));
      end
      for (int i = 0; i < n; i++) send_word(base + 16'(i));
      core_mem_we = 1'b0;
      core_done   = 1'b0;
      #1;
      check("R5 start after load", 32'(core_start), 32'd1);
      check("R5 no input at start", 32'(in_ready), 32'd0);
      @(negedge clk);
      #1 check("R5 start single", 32'(core_start), 32'd0);
      drain_and_idle("R11 busy after block");
   endtask

   initial begin
      #1000000;
      bad++;
      total++;
      $display("FAIL watchdog act=timeout exp=finish");
      report();
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      #1;
      check("R1 busy", 32'(busy), 32'd0);
      check("R1 in_ready", 32'(in_ready), 32'd1);
      check("R1 out_valid", 32'(out_valid), 32'd0);
      check("R1 core_start", 32'(core_start), 32'd0);
      check("R1 core_sin_valid", 32'(core_sin_valid), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: configuration pairs. Address 1400 lies outside the store.
      send_header(16'h2ABC);
      send_word(16'd5);
      send_word(16'd0);    send_word(16'hA000);
      send_word(16'd5);    send_word(16'hA005);
      send_word(16'd1399); send_word(16'hA577);
      send_word(16'd1400); send_word(16'hBAD0);
      send_word(16'd10);   send_word(16'hA00A);
      #1 check("R11 busy after config", 32'(busy), 32'd0);
      @(negedge clk);
      cfg_expect(11'd0,    16'hA000, "R3 cfg 0");
      cfg_expect(11'd5,    16'hA005, "R3 cfg 5");
      cfg_expect(11'd1399, 16'hA577, "R3 cfg 1399");
      cfg_expect(11'd10,   16'hA00A, "R3 cfg 10");
      cfg_expect(11'd1400, 16'h0000, "R3 out of range");

      // R4: rewrite two locations and confirm the others are kept.
      send_header(16'h0000);
      send_word(16'd2);
      send_word(16'd5);   send_word(16'hB005);
      send_word(16'd700); send_word(16'hB700);
      @(negedge clk);
      cfg_expect(11'd5,    16'hB005, "R4 rewritten 5");
      cfg_expect(11'd700,  16'hB700, "R4 rewritten 700");
      cfg_expect(11'd0,    16'hA000, "R4 kept 0");
      cfg_expect(11'd10,   16'hA00A, "R4 kept 10");
      cfg_expect(11'd1399, 16'hA577, "R4 kept 1399");

      // R2: zero length ends at once.
      send_header(16'h4000);
      send_word(16'd0);
      #1 check("R2 zero length idle", 32'(busy), 32'd0);
      @(negedge clk);
      @(negedge clk);
      check("R2 zero length no start", 32'(start_cnt), 32'd0);

      // R5: block run. Header carries ones in the ignored bits (R2).
      run_block(8, 16'h1000, 1'b0);
      // R6: block run with stray done and memory write during the load.
      cur_req = "R6";
      run_block(4, 16'h2000, 1'b1);

      // R7: unload only, no start. Address 6 must still hold 16'h1006.
      cur_req = "R7";
      send_header(16'h8000);
      exp_q.push_back(16'hC000); exp_q.push_back(16'hC001);
      exp_q.push_back(16'h2002); exp_q.push_back(16'h2003);
      exp_q.push_back(16'h1004); exp_q.push_back(16'h1005);
      exp_q.push_back(16'h1006); exp_q.push_back(16'h1007);
      send_word(16'd8);
      drain_and_idle("R11 busy after unload");
      check("R7 start count", 32'(start_cnt), 32'd2);

      // R8: stream with random readiness on both sides.
      cur_req = "R8";
      send_header(16'hC000);
      send_word(16'd20);
      for (int i = 0; i < 20; i++) exp_q.push_back(16'h3000 + 16'(i * 7) + 16'd1);
      for (int i = 0; i < 20; i++) send_word(16'h3000 + 16'(i * 7));
      drain_and_idle("R11 busy after stream");
      check("R8 same cycle in and out", 32'(both_cnt > 0), 32'd1);
      check("R8 no start in stream", 32'(start_cnt), 32'd2);

      // R9: extra input after the stream's N words is refused.
      cur_req = "R9";
      hold_out = 1'b1;
      @(negedge clk);
      @(negedge clk);
      send_header(16'hFFFF);
      send_word(16'd6);
      for (int i = 0; i < 6; i++) exp_q.push_back(16'h5000 + 16'(i) + 16'd1);
      for (int i = 0; i < 6; i++) send_word(16'h5000 + 16'(i));
      in_valid = 1'b1;
      in_data  = 16'hEEEE;
      for (int k = 0; k < 3; k++) begin
         #1;
         check("R9 in_ready after N", 32'(in_ready), 32'd0);
         check("R9 core_sin_valid after N", 32'(core_sin_valid), 32'd0);
         check("R11 busy while results wait", 32'(busy), 32'd1);
         @(negedge clk);
      end
      in_valid = 1'b0;
      hold_out = 1'b0;
      drain_and_idle("R11 busy after second stream");
      #1 check("R9 idle core_sin_valid", 32'(core_sin_valid), 32'd0);
      check("R8 all words delivered", 32'(exp_q.size()), 32'd0);

      report();
      $finish;
   end

endmodule